// File: doc/BRIEF.md
# Compare Timer with CTC and Fast-PWM Waveform

An up-counting timer of parameterised width that advances only on a tick enable from a built-in free-running prescaler. The tick divides the clock by 1, 8, 64, 256 or 1024, or it is stopped. One compare register, written by the host, drives one waveform output and a compare-match flag. An overflow flag marks each roll from the all-ones count to zero.

Four counting modes are provided. The first counts freely. The second clears the counter on compare (CTC), which with the toggle output action makes a square wave of frequency clk / (2·N·(1 + compare)). The compare register in that mode is used directly and has no shadow copy. If it is written below the live count, the match is skipped and the counter runs on through the all-ones value before it can match. The last two are single-slope fast PWM, with the period end set either at all ones or at the compare value, in non-inverting or inverting output form. Both flags stay set until the host clears them with a strobe.

Top module: `wavegen_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, `wave`, both flags and the prescaler divider are set to zero.
- R2: In mode 0 (free count) the counter adds one on each tick and wraps from all ones to 0. It changes only on a tick.
- R3: `ovf_flag` is set by the tick on which the counter rolls from all ones to 0, and reads 1 in the cycle after that edge.
- R4: `cmp_flag` is set by any tick on which the counter equals `cmp`, in every mode, and reads 1 in the cycle after that edge.
- R5: Each flag stays set until its clear strobe (`clr_cmp`, `clr_ovf`) is high at an edge. A set event on the same edge wins over the clear.
- R6: In mode 1 (CTC) the counter goes to 0 on the tick after it equals `cmp`.
- R7: In mode 1 a `cmp` value written below the current count is used at once. The counter then counts up to all ones and wraps to 0, and only after that can it match.
- R8: With `com` = 1 (toggle), `wave` inverts on each compare match. With `cmp` = 0 in mode 1, it inverts on every tick.
- R9: Mode 2 is fast PWM with TOP at all ones. Mode 3 is fast PWM with TOP equal to `cmp`. In both, the counter goes from 0 up to TOP and restarts at 0 on the next tick.
- R10: With `com` = 2 in fast PWM (non-inverting), `wave` is cleared on a match and set on the tick that restarts the count at 0. When both fall on one tick, the set wins. Outside PWM, `com` = 2 clears `wave` on a match.
- R11: With `com` = 3 in fast PWM (inverting), `wave` is set on a match and cleared on restart. Outside PWM, `com` = 3 sets `wave` on a match.
- R12: `psel` encodings are as follows. 0, 6 and 7 stop the counter. 1, 2, 3, 4 and 5 divide by 1, 8, 64, 256 and 1024. For a divide by 2^k, a tick is issued on an edge where the low k bits of the divider, which counts every clock from 0 after reset, are all ones.
- R13: With `en` low, the counter holds. With `com` = 0, `wave` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| mode | input | 2 | 0 free, 1 CTC, 2 PWM TOP=max, 3 PWM TOP=cmp |
| com | input | 2 | 0 hold, 1 toggle, 2 clear/non-inverting, 3 set/inverting |
| psel | input | 3 | Prescaler select |
| cmp | input | CNT_W | Compare value |
| clr_cmp | input | 1 | Clear strobe for cmp_flag |
| clr_ovf | input | 1 | Clear strobe for ovf_flag |
| count | output | CNT_W | Counter value |
| wave | output | 1 | Waveform output |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the timer with its defaults: an 8-bit counter and a 10-bit divider. With these values, one full 256-tick roll from all ones to zero fits into a short run. So do the late-written compare value in CTC, which must run past 255, and complete periods of both fast-PWM forms. The 10-bit divider brings the 1024 setting within reach, so the first tick can be checked for every prescale ratio, along with the stopped codes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned SEL_W = 3;

   typedef enum logic [1:0] {
      TM_FREE     = 2'd0,
      TM_CLRCMP   = 2'd1,
      TM_PWM_FULL = 2'd2,
      TM_PWM_CMP  = 2'd3
   } tmr_mode_e;

   typedef enum logic [1:0] {
      WO_HOLD   = 2'd0,
      WO_TOGGLE = 2'd1,
      WO_LOW    = 2'd2,
      WO_HIGH   = 2'd3
   } wo_act_e;

   // log2 of the division ratio for each prescaler select
   function automatic int unsigned sel_shift(input int unsigned s);
      case (s)
         1: return 0;
         2: return 3;
         3: return 6;
         4: return 8;
         5: return 10;
         default: return 0;
      endcase
   endfunction

   function automatic bit sel_running(input int unsigned s);
      return (s >= 1) && (s <= 5);
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int unsigned PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [SEL_W-1:0] psel,
   output logic             tick
);
   localparam int unsigned NSEL = 1 << SEL_W;

   logic [PRE_W-1:0] div_q;
   logic [NSEL-1:0]  hit_v;

   if (PRE_W < 10) begin : g_bad_pre
      $error("tmr_prescale: PRE_W must cover a divide by 1024");
   end

   always_ff @(posedge clk) begin
      if (rst) div_q <= '0;
      else     div_q <= div_q + 1'b1;
   end

   for (genvar s = 0; s < NSEL; s++) begin : g_sel
      localparam int unsigned SH = sel_shift(s);
      if (!sel_running(s)) begin : g_stop
         assign hit_v[s] = 1'b0;
      end else if (SH == 0) begin : g_every
         assign hit_v[s] = 1'b1;
      end else begin : g_div
         assign hit_v[s] = &div_q[SH-1:0];
      end
   end

   assign tick = en & hit_v[psel];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  tmr_mode_e        mode,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] count,
   output logic             match_ev,
   output logic             restart_ev,
   output logic             roll_ev
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] top;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      unique case (mode)
         TM_CLRCMP, TM_PWM_CMP: top = cmp;
         default:               top = CNT_MAX;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (cnt_q == top) cnt_q <= '0;
         else              cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count      = cnt_q;
   assign match_ev   = tick && (cnt_q == cmp);
   assign restart_ev = tick && (cnt_q == top);
   assign roll_ev    = tick && (cnt_q == CNT_MAX);
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
   import tmr_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  tmr_mode_e mode,
   input  wo_act_e   com,
   input  logic      match_ev,
   input  logic      restart_ev,
   output logic      wave
);
   logic wave_q;
   logic wave_d;
   logic pwm;

   assign pwm = (mode == TM_PWM_FULL) || (mode == TM_PWM_CMP);

   always_comb begin
      wave_d = wave_q;
      unique case (com)
         WO_TOGGLE: if (match_ev) wave_d = ~wave_q;
         WO_LOW: begin
            if (match_ev)          wave_d = 1'b0;
            if (pwm && restart_ev) wave_d = 1'b1;
         end
         WO_HIGH: begin
            if (match_ev)          wave_d = 1'b1;
            if (pwm && restart_ev) wave_d = 1'b0;
         end
         default: wave_d = wave_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) wave_q <= 1'b0;
      else     wave_q <= wave_d;
   end

   assign wave = wave_q;
endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [1:0]       mode,
   input  logic [1:0]       com,
   input  logic [2:0]       psel,
   input  logic [CNT_W-1:0] cmp,
   input  logic             clr_cmp,
   input  logic             clr_ovf,
   output logic [CNT_W-1:0] count,
   output logic             wave,
   output logic             cmp_flag,
   output logic             ovf_flag
);
   localparam int unsigned NFLAG = 2;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("wavegen_timer: CNT_W must be at least 2");
   end

   logic            tick;
   logic            match_ev;
   logic            restart_ev;
   logic            roll_ev;
   logic [NFLAG-1:0] set_v;
   logic [NFLAG-1:0] clr_v;
   logic [NFLAG-1:0] flag_q;

   tmr_prescale #(.PRE_W(PRE_W)) i_pre (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .psel (psel),
      .tick (tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .mode       (tmr_mode_e'(mode)),
      .cmp        (cmp),
      .count      (count),
      .match_ev   (match_ev),
      .restart_ev (restart_ev),
      .roll_ev    (roll_ev)
   );

   tmr_wave i_wave (
      .clk        (clk),
      .rst        (rst),
      .mode       (tmr_mode_e'(mode)),
      .com        (wo_act_e'(com)),
      .match_ev   (match_ev),
      .restart_ev (restart_ev),
      .wave       (wave)
   );

   assign set_v = {roll_ev, match_ev};
   assign clr_v = {clr_ovf, clr_cmp};

   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst)           flag_q[f] <= 1'b0;
         else if (set_v[f]) flag_q[f] <= 1'b1;
         else if (clr_v[f]) flag_q[f] <= 1'b0;
      end
   end

   assign cmp_flag = flag_q[0];
   assign ovf_flag = flag_q[1];
endmodule

// File: rtl/tmr_check.sv
module tmr_check #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic             tick,
   input logic [1:0]       mode,
   input logic [1:0]       com,
   input logic [2:0]       psel,
   input logic [CNT_W-1:0] cmp,
   input logic             clr_ovf,
   input logic [CNT_W-1:0] count,
   input logic             wave,
   input logic             cmp_flag,
   input logic             ovf_flag
);
   logic [CNT_W-1:0] cnt_inc;
   assign cnt_inc = count + 1'b1;

   p_free_step_r2: assert property (@(posedge clk) disable iff (rst)
      (tick && mode == 2'd0) |=> (count == $past(cnt_inc)));

   p_roll_flag_r3: assert property (@(posedge clk) disable iff (rst)
      (tick && count == '1) |=> (ovf_flag && count == '0));

   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag && !clr_ovf) |=> ovf_flag);

   p_ctc_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (tick && mode == 2'd1 && count == cmp) |=> (count == '0 && cmp_flag));

   p_pwm_restart_r10: assert property (@(posedge clk) disable iff (rst)
      (tick && mode == 2'd2 && com == 2'd2 && count == '1) |=> wave);

   p_stopped_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (psel == 3'd0 || psel == 3'd6 || psel == 3'd7) |=> $stable(count));

   p_disabled_hold_r13: assert property (@(posedge clk) disable iff (rst)
      (!en) |=> $stable(count));
endmodule

bind wavegen_timer tmr_check #(.CNT_W(CNT_W)) i_tmr_check (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .tick     (tick),
   .mode     (mode),
   .com      (com),
   .psel     (psel),
   .cmp      (cmp),
   .clr_ovf  (clr_ovf),
   .count    (count),
   .wave     (wave),
   .cmp_flag (cmp_flag),
   .ovf_flag (ovf_flag)
);

// File: tb/test_wavegen_timer.sv
`timescale 1ns/1ps
module test_wavegen_timer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [1:0] com = 2'd0;
   logic [2:0] psel = 3'd0;
   logic [7:0] cmp = 8'd0;
   logic       clr_cmp = 1'b0;
   logic       clr_ovf = 1'b0;
   logic [7:0] count;
   logic       wave;
   logic       cmp_flag;
   logic       ovf_flag;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      string req;
      int    sel;
      int    exp;
   } item_t;

   item_t sb_q[$];
   event  chk_ev;

   always #2.5 clk = ~clk;

   wavegen_timer i_wavegen_timer (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .mode     (mode),
      .com      (com),
      .psel     (psel),
      .cmp      (cmp),
      .clr_cmp  (clr_cmp),
      .clr_ovf  (clr_ovf),
      .count    (count),
      .wave     (wave),
      .cmp_flag (cmp_flag),
      .ovf_flag (ovf_flag)
   );

   function automatic int pick(input int sel);
      case (sel)
         0: return int'(count);
         1: return int'(wave);
         2: return int'(cmp_flag);
         default: return int'(ovf_flag);
      endcase
   endfunction

   function automatic string sel_name(input int sel);
      case (sel)
         0: return "count";
         1: return "wave";
         2: return "cmp_flag";
         default: return "ovf_flag";
      endcase
   endfunction

   // monitor: pops expected items and compares with the live outputs
   initial begin
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            int    act;
            it  = sb_q.pop_front();
            act = pick(it.sel);
            tests++;
            if (act != it.exp) begin
               fails++;
               $display("FAIL %s %s actual=%0d expected=%0d", it.req, sel_name(it.sel), act, it.exp);
            end
         end
      end
   end

   task automatic expect_val(input string req, input int sel, input int exp);
      item_t it;
      it.req = req;
      it.sel = sel;
      it.exp = exp;
      sb_q.push_back(it);
      -> chk_ev;
      #0.1;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart(input logic [1:0] m, input logic [1:0] c,
                          input logic [2:0] p, input logic [7:0] v);
      @(negedge clk);
      mode = m; com = c; psel = p; cmp = v;
      en = 1'b1; clr_cmp = 1'b0; clr_ovf = 1'b0;
      rst = 1'b1;
      step(2);
      rst = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // free count, compare flag, overflow, flag clear priority
      restart(2'd0, 2'd0, 3'd1, 8'd128);
      step(10);  expect_val("R2", 0, 10);
      step(118); expect_val("R4", 0, 128); expect_val("R4", 2, 0);
      step(1);   expect_val("R4", 2, 1);
      step(126); expect_val("R2", 0, 255); expect_val("R3", 3, 0); expect_val("R13", 1, 0);
      clr_ovf = 1'b1; clr_cmp = 1'b1;
      step(1);   expect_val("R2", 0, 0); expect_val("R5", 3, 1); expect_val("R5", 2, 0);
      clr_cmp = 1'b0;
      step(1);   expect_val("R5", 3, 0); expect_val("R2", 0, 1);
      clr_ovf = 1'b0; en = 1'b0;
      step(5);   expect_val("R13", 0, 1);
      en = 1'b1;

      // CTC with toggle
      restart(2'd1, 2'd1, 3'd1, 8'd4);
      step(4);   expect_val("R6", 0, 4); expect_val("R8", 1, 0);
      step(1);   expect_val("R6", 0, 0); expect_val("R8", 1, 1); expect_val("R4", 2, 1);
      step(7);   expect_val("R6", 0, 2); expect_val("R8", 1, 0);
      step(3);   expect_val("R6", 0, 0); expect_val("R8", 1, 1);

      // reset clears everything
      restart(2'd1, 2'd1, 3'd1, 8'd4);
      expect_val("R1", 0, 0); expect_val("R1", 1, 0);
      expect_val("R1", 2, 0); expect_val("R1", 3, 0);

      // CTC compare written below the count
      restart(2'd1, 2'd0, 3'd1, 8'd200);
      step(100); expect_val("R7", 0, 100);
      cmp = 8'd50;
      step(155); expect_val("R7", 0, 255); expect_val("R7", 2, 0);
      step(1);   expect_val("R7", 0, 0); expect_val("R3", 3, 1);
      step(50);  expect_val("R7", 0, 50); expect_val("R7", 2, 0);
      step(1);   expect_val("R7", 0, 0); expect_val("R7", 2, 1);

      // CTC compare zero toggles every tick
      restart(2'd1, 2'd1, 3'd1, 8'd0);
      step(1);   expect_val("R8", 1, 1); expect_val("R8", 0, 0);
      step(1);   expect_val("R8", 1, 0);
      step(1);   expect_val("R8", 1, 1);

      // fast PWM, TOP = max, non-inverting
      restart(2'd2, 2'd2, 3'd1, 8'd63);
      step(64);  expect_val("R10", 1, 0); expect_val("R9", 0, 64);
      step(192); expect_val("R10", 1, 1); expect_val("R9", 0, 0); expect_val("R9", 3, 1);
      step(63);  expect_val("R10", 1, 1); expect_val("R9", 0, 63);
      step(1);   expect_val("R10", 1, 0);

      // fast PWM, TOP = max, inverting
      restart(2'd2, 2'd3, 3'd1, 8'd63);
      step(64);  expect_val("R11", 1, 1);
      step(192); expect_val("R11", 1, 0);
      step(64);  expect_val("R11", 1, 1);

      // fast PWM, TOP = cmp
      restart(2'd3, 2'd2, 3'd1, 8'd9);
      step(9);   expect_val("R9", 0, 9); expect_val("R10", 1, 0);
      step(1);   expect_val("R9", 0, 0); expect_val("R10", 1, 1);
      step(3);   expect_val("R9", 0, 3);
      step(27);  expect_val("R9", 0, 0); expect_val("R9", 3, 0); expect_val("R10", 1, 1);

      // prescaler ratios and stopped codes
      restart(2'd0, 2'd0, 3'd2, 8'd0);
      step(7);   expect_val("R12", 0, 0);
      step(1);   expect_val("R12", 0, 1);
      step(16);  expect_val("R12", 0, 3);
      restart(2'd0, 2'd0, 3'd3, 8'd0);
      step(63);  expect_val("R12", 0, 0);
      step(1);   expect_val("R12", 0, 1);
      restart(2'd0, 2'd0, 3'd4, 8'd0);
      step(255); expect_val("R12", 0, 0);
      step(1);   expect_val("R12", 0, 1);
      restart(2'd0, 2'd0, 3'd5, 8'd0);
      step(1023); expect_val("R12", 0, 0);
      step(1);    expect_val("R12", 0, 1);
      psel = 3'd0;
      step(50);  expect_val("R12", 0, 1);
      psel = 3'd6;
      step(50);  expect_val("R12", 0, 1);

      #1;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule